// File: doc/BRIEF.md
# Operate Execute Unit with Condition Flags

This unit executes the three data-manipulation instructions of a 16-bit machine with eight general registers: a two's-complement add, a bitwise AND and a bitwise complement. Each cycle it may accept one instruction word. It decodes the word and presents two read indices to an external register file, which returns the operand values in the same cycle. The unit then selects the second operand, either the register value or a sign-extended 5-bit literal, and computes the result. On the next clock edge it presents the destination index, the result and a write strobe.

The unit also holds the machine's three condition flags (negative, zero, positive) as a small state machine with the states `CC_NEG`, `CC_ZERO` and `CC_POS`. Reset puts it in `CC_ZERO`. On every edge where a well-formed operate instruction completes, it moves to `CC_NEG` if the result has bit 15 set, to `CC_ZERO` if the result is all zeros, and to `CC_POS` otherwise. It stays in its current state on every other edge. Words whose opcode is not one of the three are reported on `not_operate`. Operate words with malformed filler bits are reported on `illegal_enc`. Neither kind writes a register or moves the flags.

Top module: `opexec_unit`

## Requirements
- R1: Opcode field [15:12] selects the operation: 0001 adds, 0101 ANDs bitwise, 1001 complements bitwise. The result appears on `wr_data` with `wr_en` high on the clock edge after the word is presented with `instr_valid` high.
- R2: `wr_idx` carries field [11:9] of the word. `rd_a_idx` carries field [8:6]. `rd_b_idx` carries field [2:0].
- R3: For add and AND with bit 5 set, the second operand is bits [4:0] read as a two's-complement value and sign-extended to 16 bits. With bit 5 clear, the second operand is `rd_b_data`.
- R4: The add is modulo 2^16, and any carry out of bit 15 is dropped.
- R5: The complement result is the bitwise inverse of `rd_a_data`.
- R6: Exactly one of `cc_n`, `cc_z`, `cc_p` is high at all times after reset. After a write, N equals bit 15 of `wr_data`, Z is high when `wr_data` is zero, and P is high otherwise.
- R7: During and right after reset, `{cc_n,cc_z,cc_p}` is 010 and `wr_en`, `illegal_enc` and `not_operate` are low.
- R8: A valid word whose opcode is not 0001, 0101 or 1001 raises `not_operate` for one cycle. It leaves `wr_en` low and the flags unchanged.
- R9: An add or AND with bit 5 clear and bits [4:3] nonzero, or a complement whose bits [5:0] are not 111111, raises `illegal_enc` for one cycle. It leaves `wr_en` low and the flags unchanged.
- R10: When `instr_valid` is low, the next cycle shows `wr_en`, `illegal_enc` and `not_operate` all low, and the flags keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| rd_a_idx | output | 3 | First read index to the register file |
| rd_b_idx | output | 3 | Second read index to the register file |
| rd_a_data | input | 16 | Value of register `rd_a_idx` |
| rd_b_data | input | 16 | Value of register `rd_b_idx` |
| wr_en | output | 1 | Write strobe for the destination register |
| wr_idx | output | 3 | Destination register index |
| wr_data | output | 16 | Result value |
| illegal_enc | output | 1 | Malformed operate word seen |
| not_operate | output | 1 | Word was not an operate instruction |
| cc_n | output | 1 | Negative flag |
| cc_z | output | 1 | Zero flag |
| cc_p | output | 1 | Positive flag |

## Verification
Operands are chosen so that each flag state is reached from a different one. The values include 1+1 (positive), 0x7FFF+1 (wraps to negative, so a carry or overflow leak shows) and 0xFFFF+1 (wraps to zero). Literal operands of -2, +15, 0 and -1 separate sign extension from zero extension and check whether bit 5 is honoured. Complements of 0 and 0xFFFF cover the N and Z results. Malformed and foreign opcodes are issued while the flags sit in a state other than zero, and idle cycles are mixed in, so that a wrong write or a flag that moves when it should hold is visible at the ports.

// File: rtl/opx_pkg.sv
package opx_pkg;
    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_AND = 2'd1,
        ALU_NOT = 2'd2
    } alu_fn_t;

    typedef enum logic [1:0] {
        CC_NEG  = 2'd0,
        CC_ZERO = 2'd1,
        CC_POS  = 2'd2
    } cc_state_t;
endpackage

// File: rtl/opx_decode.sv
module opx_decode
    import opx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int IMM_W  = 5
) (
    input  logic [15:0]       word,
    output logic              is_op,
    output logic              bad_enc,
    output alu_fn_t           fn,
    output logic              use_imm,
    output logic [DATA_W-1:0] imm_ext,
    output logic [IDX_W-1:0]  dst,
    output logic [IDX_W-1:0]  src_a,
    output logic [IDX_W-1:0]  src_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [3:0]       opc;
    logic [IMM_W-1:0] imm_raw;

    assign opc     = word[15:12];
    assign dst     = word[11:9];
    assign src_a   = word[8:6];
    assign src_b   = word[2:0];
    assign imm_raw = word[IMM_W-1:0];
    assign imm_ext = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};

    always_comb begin
        is_op   = 1'b0;
        bad_enc = 1'b0;
        fn      = ALU_ADD;
        use_imm = 1'b0;
        unique case (opc)
            OPC_ADD, OPC_AND: begin
                is_op   = 1'b1;
                fn      = (opc == OPC_ADD) ? ALU_ADD : ALU_AND;
                use_imm = word[5];
                bad_enc = !word[5] && (word[4:3] != 2'b00);
            end
            OPC_NOT: begin
                is_op   = 1'b1;
                fn      = ALU_NOT;
                bad_enc = (word[5:0] != 6'b111111);
            end
            default: begin
                is_op = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/opx_alu.sv
module opx_alu
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_t           fn,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        unique case (fn)
            ALU_ADD: res = opa + opb;
            ALU_AND: res = opa & opb;
            ALU_NOT: res = ~opa;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/opx_ccreg.sv
module opx_ccreg
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_p
);
    cc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CC_ZERO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (upd) begin
            if (result[DATA_W-1])   state_d = CC_NEG;
            else if (result == '0)  state_d = CC_ZERO;
            else                    state_d = CC_POS;
        end
    end

    always_comb begin
        unique case (state_q)
            CC_NEG:  {flag_n, flag_z, flag_p} = 3'b100;
            CC_ZERO: {flag_n, flag_z, flag_p} = 3'b010;
            CC_POS:  {flag_n, flag_z, flag_p} = 3'b001;
            default: {flag_n, flag_z, flag_p} = 3'b010;
        endcase
    end
endmodule

// File: rtl/opexec_unit.sv
module opexec_unit
    import opx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int IMM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    output logic [IDX_W-1:0]  rd_a_idx,
    output logic [IDX_W-1:0]  rd_b_idx,
    input  logic [DATA_W-1:0] rd_a_data,
    input  logic [DATA_W-1:0] rd_b_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              illegal_enc,
    output logic              not_operate,
    output logic              cc_n,
    output logic              cc_z,
    output logic              cc_p
);
    logic              dec_is_op, dec_bad, dec_imm;
    alu_fn_t           dec_fn;
    logic [DATA_W-1:0] dec_imm_ext, opb, alu_res;
    logic [IDX_W-1:0]  dec_dst;
    logic              commit;

    opx_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_dec (
        .word    (instr),
        .is_op   (dec_is_op),
        .bad_enc (dec_bad),
        .fn      (dec_fn),
        .use_imm (dec_imm),
        .imm_ext (dec_imm_ext),
        .dst     (dec_dst),
        .src_a   (rd_a_idx),
        .src_b   (rd_b_idx)
    );

    assign opb = dec_imm ? dec_imm_ext : rd_b_data;

    opx_alu #(.DATA_W(DATA_W)) u_alu (
        .fn  (dec_fn),
        .opa (rd_a_data),
        .opb (opb),
        .res (alu_res)
    );

    assign commit = instr_valid && dec_is_op && !dec_bad;

    opx_ccreg #(.DATA_W(DATA_W)) u_cc (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (commit),
        .result (alu_res),
        .flag_n (cc_n),
        .flag_z (cc_z),
        .flag_p (cc_p)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en       <= 1'b0;
            wr_idx      <= '0;
            wr_data     <= '0;
            illegal_enc <= 1'b0;
            not_operate <= 1'b0;
        end else begin
            wr_en       <= commit;
            illegal_enc <= instr_valid && dec_is_op && dec_bad;
            not_operate <= instr_valid && !dec_is_op;
            if (commit) begin
                wr_idx  <= dec_dst;
                wr_data <= alu_res;
            end
        end
    end
endmodule

// File: rtl/opexec_unit_chk.sv
module opexec_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              illegal_enc,
    input logic              not_operate,
    input logic              cc_n,
    input logic              cc_z,
    input logic              cc_p
);
    assert_cc_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cc_n, cc_z, cc_p}) == 1);

    assert_cc_tracks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cc_n == wr_data[DATA_W-1]) && (cc_z == (wr_data == '0)));

    assert_no_write_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_enc |-> !wr_en && $stable({cc_n, cc_z, cc_p}));

    assert_no_write_foreign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        not_operate |-> !wr_en && $stable({cc_n, cc_z, cc_p}));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !wr_en && !illegal_enc && !not_operate);

    assert_status_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_en, illegal_enc, not_operate}) <= 1);
endmodule

bind opexec_unit opexec_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .illegal_enc (illegal_enc),
    .not_operate (not_operate),
    .cc_n        (cc_n),
    .cc_z        (cc_z),
    .cc_p        (cc_p)
);

// File: tb/opexec_unit_tb.sv
module opexec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [2:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [15:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, illegal_enc, not_operate, cc_n, cc_z, cc_p;

    logic [15:0] rf [8];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        wen;
        logic [2:0]  idx;
        logic [15:0] data;
        logic        ill;
        logic        nop;
        logic [2:0]  cc;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    logic [2:0] cc_model = 3'b010;

    always #2 clk = ~clk;

    assign rd_a_data = rf[rd_a_idx];
    assign rd_b_data = rf[rd_b_idx];

    opexec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .illegal_enc(illegal_enc), .not_operate(not_operate),
        .cc_n(cc_n), .cc_z(cc_z), .cc_p(cc_p)
    );

    function automatic logic [15:0] enc_rr(logic [3:0] op, logic [2:0] d, logic [2:0] a, logic [2:0] b);
        return {op, d, a, 3'b000, b};
    endfunction
    function automatic logic [15:0] enc_ri(logic [3:0] op, logic [2:0] d, logic [2:0] a, logic [4:0] k);
        return {op, d, a, 1'b1, k};
    endfunction
    function automatic logic [15:0] enc_not(logic [2:0] d, logic [2:0] a);
        return {4'b1001, d, a, 6'b111111};
    endfunction

    // Expected item computed from the requirement text, not from the RTL.
    task automatic drive(input logic v, input logic [15:0] w, input string tag);
        exp_t e;
        logic [15:0] a, b, r;
        logic opok, bad;
        @(negedge clk);
        instr_valid = v;
        instr = w;
        e = '0;
        a = rf[w[8:6]];
        b = w[5] ? {{11{w[4]}}, w[4:0]} : rf[w[2:0]];
        opok = (w[15:12] == 4'b0001) || (w[15:12] == 4'b0101) || (w[15:12] == 4'b1001);
        bad = (w[15:12] == 4'b1001) ? (w[5:0] != 6'h3F) : (!w[5] && w[4:3] != 2'b00);
        r = (w[15:12] == 4'b0001) ? a + b : (w[15:12] == 4'b0101) ? (a & b) : ~a;
        if (v && !opok) e.nop = 1'b1;
        else if (v && bad) e.ill = 1'b1;
        else if (v) begin
            e.wen = 1'b1; e.idx = w[11:9]; e.data = r;
            cc_model = r[15] ? 3'b100 : (r == 16'h0) ? 3'b010 : 3'b001;
        end
        e.cc = cc_model;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        exp_t e, act;
        string t;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act.wen = wr_en; act.idx = wr_idx; act.data = wr_data;
                act.ill = illegal_enc; act.nop = not_operate; act.cc = {cc_n, cc_z, cc_p};
                if (!e.wen) begin act.idx = 3'd0; act.data = 16'h0; end
                n_checks++;
                if (act !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual wen=%0b idx=%0d data=%h ill=%0b nop=%0b cc=%b expected wen=%0b idx=%0d data=%h ill=%0b nop=%0b cc=%b",
                        t, act.wen, act.idx, act.data, act.ill, act.nop, act.cc,
                        e.wen, e.idx, e.data, e.ill, e.nop, e.cc);
                end
            end
        end
    end

    initial begin : watchdog
        #40000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stimulus
        rf[0] = 16'h0000; rf[1] = 16'h0001; rf[2] = 16'h7FFF; rf[3] = 16'h8000;
        rf[4] = 16'hFFFF; rf[5] = 16'h1234; rf[6] = 16'h00F0; rf[7] = 16'hFFFE;
        repeat (3) @(negedge clk);
        // R7: reset state visible while reset is held
        n_checks++;
        if ({cc_n, cc_z, cc_p, wr_en, illegal_enc, not_operate} !== 6'b010000) begin
            n_fail++;
            $display("FAIL R7: actual cc=%b wen=%0b ill=%0b nop=%0b expected cc=010 wen=0 ill=0 nop=0",
                {cc_n, cc_z, cc_p}, wr_en, illegal_enc, not_operate);
        end
        rst_n = 1'b1;
        drive(1'b0, 16'h0000, "R7 idle after reset");
        drive(1'b1, enc_rr(4'b0001, 3'd3, 3'd1, 3'd1), "R1 R2 add positive");
        drive(1'b1, enc_rr(4'b0001, 3'd6, 3'd2, 3'd1), "R4 add overflow to negative");
        drive(1'b1, enc_rr(4'b0001, 3'd2, 3'd4, 3'd1), "R4 add wrap to zero");
        drive(1'b1, enc_ri(4'b0001, 3'd1, 3'd5, 5'b11110), "R3 add imm -2");
        drive(1'b1, enc_ri(4'b0001, 3'd7, 3'd0, 5'b01111), "R3 add imm +15");
        drive(1'b1, enc_rr(4'b0101, 3'd4, 3'd5, 3'd6), "R1 and register");
        drive(1'b1, enc_ri(4'b0101, 3'd5, 3'd5, 5'b00000), "R3 and imm zero");
        drive(1'b1, enc_ri(4'b0101, 3'd0, 3'd3, 5'b11111), "R3 and imm -1");
        drive(1'b1, enc_not(3'd2, 3'd0), "R5 not of zero");
        drive(1'b1, enc_not(3'd1, 3'd4), "R5 not to zero");
        drive(1'b1, enc_rr(4'b0001, 3'd0, 3'd1, 3'd1), "R6 set positive");
        drive(1'b1, {4'b0001, 3'd2, 3'd1, 3'b001, 3'd1}, "R9 add bits43 nonzero");
        drive(1'b1, {4'b0101, 3'd2, 3'd1, 3'b010, 3'd1}, "R9 and bits43 nonzero");
        drive(1'b1, {4'b1001, 3'd2, 3'd1, 6'b111110}, "R9 not bad filler");
        drive(1'b1, 16'h2A05, "R8 opcode 0010");
        drive(1'b1, 16'h0E00, "R8 opcode 0000");
        drive(1'b1, 16'hF025, "R8 opcode 1111");
        drive(1'b0, enc_rr(4'b0001, 3'd3, 3'd4, 3'd4), "R10 idle with add word");
        drive(1'b1, enc_rr(4'b0001, 3'd3, 3'd7, 3'd7), "R6 add negative");
        drive(1'b0, 16'h0000, "R10 idle hold negative");
        drive(1'b1, enc_ri(4'b0001, 3'd5, 3'd2, 5'b10000), "R3 add imm -16");
        drive(1'b0, 16'h0000, "R10 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule